// File: doc/BRIEF.md
# Video Timing Interrupt and Enable Controller

This block is the control and status core of a video timing unit. A plain word-addressed register port gives software four 32-bit words: a control word, a sticky event status word, a sticky lock-error word and an interrupt mask. The control word sets the detector and generator enables. A master bit turns on both sub-units at once. Two individual bits turn each one on alone.

Single-cycle strobes come in from the timing detector, the timing generator and sixteen frame-sync comparators. A live lock level and six lock-error strobes also come in. The block latches all of these into write-one-to-clear bits. One registered interrupt line goes high whenever any unmasked status bit is set.

Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from the currently selected word. The word index `reg_addr` decodes as: 0 control, 1 status, 2 error, 3 interrupt mask.

Top module: `vtc_irq_ctrl`

## Requirements
- R1: Control bit 0 is the master enable, bit 3 is the detector enable and bit 2 is the generator enable. `det_en` = bit0 OR bit3 and `gen_en` = bit0 OR bit2. Only bits 0, 2 and 3 are stored and read back; all other control bits read 0.
- R2: An event strobe sets its status bit on the next clock edge. The bits are: frame-sync event k sets bit 16+k (k = 0..15), generated active-video start sets bit 13, generated vertical-blank start sets bit 12, detected active-video start sets bit 11 and detected vertical-blank start sets bit 10.
- R3: Writing 1 to a set status, error or mask-independent sticky bit clears it. Writing 1 to a clear bit, or writing 0, leaves the bit unchanged.
- R4: When a set strobe and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: A rising edge on `lock_live` sets status bit 8 and a falling edge sets status bit 9. Once cleared, bit 8 stays clear while `lock_live` stays high.
- R6: Error strobe `lock_err[j]` sets error bit 16+j. The strobes are j=0 vertical blank, 1 horizontal blank, 2 vertical sync, 3 horizontal sync, 4 active video, 5 active chroma.
- R7: `irq` is a register that takes the OR over all bits of (status AND mask). It follows a status or mask change one clock later, and stays low while the mask is zero.
- R8: Reset clears every word and all outputs. Reserved bits always read 0: status bits 15:14 and 7:0, error bits outside 21:16.
- R9: The mask word stores bits 31:16 and 13:8 as written. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Word index for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| fsync_evt | input | 16 | Frame-sync comparator strobes |
| gen_av_start | input | 1 | Generated active-video start strobe |
| gen_vb_start | input | 1 | Generated vertical-blank start strobe |
| det_av_start | input | 1 | Detected active-video start strobe |
| det_vb_start | input | 1 | Detected vertical-blank start strobe |
| lock_live | input | 1 | Real-time lock level from the detector |
| lock_err | input | 6 | Lock-error strobes |
| det_en | output | 1 | Effective detector enable |
| gen_en | output | 1 | Effective generator enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a set strobe and a clear write into the same status bit in the same cycle. A design where the clear wins would read that bit back as zero. It clears the lock bit while `lock_live` is still high. A level-triggered latch would set the bit again at once instead of waiting for the next rising edge. It writes ones to bits that are already clear, and all ones to the control and mask words. A design that toggled bits, or stored reserved bits, would read back a wrong pattern. It also checks that `irq` stays low when an event arrives at a masked bit. A design that ignored the mask would raise the line anyway.

// File: rtl/vtc_irq_pkg.sv
package vtc_irq_pkg;
  localparam int WORD_W  = 32;
  localparam int FSYNC_N = 16;
  localparam int ERR_N   = 6;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ERR  = 2'd2,
    SEL_MASK = 2'd3
  } reg_sel_e;

  // status bit positions that neighbours and software decode
  localparam int B_LOCK     = 8;
  localparam int B_UNLOCK   = 9;
  localparam int B_DET_VB   = 10;
  localparam int B_DET_AV   = 11;
  localparam int B_GEN_VB   = 12;
  localparam int B_GEN_AV   = 13;
  localparam int B_FSYNC_LO = 16;
  localparam int B_ERR_LO   = 16;

  localparam logic [WORD_W-1:0] STAT_KEEP = 32'hFFFF_3F00;
  localparam logic [WORD_W-1:0] ERR_KEEP  = 32'h003F_0000;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0000_000D;
endpackage

// File: rtl/vtc_w1c_bank.sv
module vtc_w1c_bank #(
  parameter int              WIDTH = 32,
  parameter logic [WIDTH-1:0] KEEP = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_en,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic bit_q;
      logic wipe;
      assign wipe = clr_en & clr_data[i];
      always_ff @(posedge clk) begin
        if (!rst_n)        bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;
        else if (wipe)     bit_q <= 1'b0;
      end
      assign q[i] = bit_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q[i]); // R4
      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_data[i] && !set_i[i]) |=> !q[i]); // R3
      AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i[i] && !(clr_en && clr_data[i])) |=> (q[i] == $past(q[i]))); // R3
    end else begin : g_rsv
      logic unused_in;
      assign unused_in = set_i[i] ^ clr_data[i];
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/vtc_enable_ctrl.sv
module vtc_enable_ctrl
  import vtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              det_en,
  output logic              gen_en
);
  localparam int B_MASTER = 0;
  localparam int B_GEN    = 2;
  localparam int B_DET    = 3;

  always_ff @(posedge clk) begin
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & CTRL_KEEP;
  end

  assign det_en = ctrl_q[B_MASTER] | ctrl_q[B_DET];
  assign gen_en = ctrl_q[B_MASTER] | ctrl_q[B_GEN];

  AST_MASTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_MASTER]) |=> (det_en && gen_en)); // R1
  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3:0] == 4'b0000) |=> (!det_en && !gen_en)); // R1
endmodule

// File: rtl/vtc_irq_merge.sv
module vtc_irq_merge
  import vtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] stat_q,
  output logic [WORD_W-1:0] mask_q,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data & STAT_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(stat_q & mask_q);
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '0) |-> !irq); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q) == '0) |-> !irq); // R7
endmodule

// File: rtl/vtc_irq_ctrl.sv
module vtc_irq_ctrl
  import vtc_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [15:0] fsync_evt,
  input  logic        gen_av_start,
  input  logic        gen_vb_start,
  input  logic        det_av_start,
  input  logic        det_vb_start,
  input  logic        lock_live,
  input  logic [5:0]  lock_err,
  output logic        det_en,
  output logic        gen_en,
  output logic        irq
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  logic [WORD_W-1:0] ctrl_q, stat_q, err_q, mask_q;
  logic [WORD_W-1:0] stat_set, err_set;
  logic lock_d, lock_rise, lock_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) lock_d <= 1'b0;
    else        lock_d <= lock_live;
  end
  assign lock_rise = lock_live & ~lock_d;
  assign lock_fall = ~lock_live & lock_d;

  always_comb begin
    stat_set = '0;
    stat_set[B_FSYNC_LO +: FSYNC_N] = fsync_evt;
    stat_set[B_GEN_AV]  = gen_av_start;
    stat_set[B_GEN_VB]  = gen_vb_start;
    stat_set[B_DET_AV]  = det_av_start;
    stat_set[B_DET_VB]  = det_vb_start;
    stat_set[B_UNLOCK]  = lock_fall;
    stat_set[B_LOCK]    = lock_rise;
    err_set = '0;
    err_set[B_ERR_LO +: ERR_N] = lock_err;
  end

  vtc_enable_ctrl u_enable (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr && sel == SEL_CTRL), .wr_data(reg_wdata),
    .ctrl_q(ctrl_q), .det_en(det_en), .gen_en(gen_en)
  );

  vtc_w1c_bank #(.WIDTH(WORD_W), .KEEP(STAT_KEEP)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(stat_set),
    .clr_en(reg_wr && sel == SEL_STAT), .clr_data(reg_wdata), .q(stat_q)
  );

  vtc_w1c_bank #(.WIDTH(WORD_W), .KEEP(ERR_KEEP)) u_error (
    .clk(clk), .rst_n(rst_n), .set_i(err_set),
    .clr_en(reg_wr && sel == SEL_ERR), .clr_data(reg_wdata), .q(err_q)
  );

  vtc_irq_merge u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(reg_wr && sel == SEL_MASK), .wr_data(reg_wdata),
    .stat_q(stat_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_STAT: reg_rdata = stat_q;
      SEL_ERR:  reg_rdata = err_q;
      default:  reg_rdata = mask_q;
    endcase
  end

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_live && !lock_d) |=> stat_q[B_LOCK]); // R5
  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_live && lock_d) |=> stat_q[B_UNLOCK]); // R5
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~STAT_KEEP) == '0) && ((err_q & ~ERR_KEEP) == '0)); // R8
endmodule

// File: tb/vtc_irq_ctrl_test.sv
module vtc_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] fsync_evt = '0;
  logic        gen_av_start = 1'b0, gen_vb_start = 1'b0;
  logic        det_av_start = 1'b0, det_vb_start = 1'b0;
  logic        lock_live = 1'b0;
  logic [5:0]  lock_err = '0;
  logic        det_en, gen_en, irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  vtc_irq_ctrl uut (.*);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_EV = 2'd2, OP_OUT = 2'd3;
  localparam int NV = 32;
  // {op, addr, data, expected}; OP_OUT expected = {irq, gen_en, det_en}
  localparam logic [67:0] VEC [NV] = '{
    {OP_RD, 2'd0, 32'h0, 32'h0},                 // 0  R8
    {OP_RD, 2'd1, 32'h0, 32'h0},                 // 1  R8
    {OP_OUT,2'd0, 32'h0, 32'h0},                 // 2  R8
    {OP_WR, 2'd0, 32'h1, 32'h0},                 // 3
    {OP_OUT,2'd0, 32'h0, 32'h3},                 // 4  R1
    {OP_WR, 2'd0, 32'h8, 32'h0},                 // 5
    {OP_OUT,2'd0, 32'h0, 32'h1},                 // 6  R1
    {OP_WR, 2'd0, 32'h4, 32'h0},                 // 7
    {OP_OUT,2'd0, 32'h0, 32'h2},                 // 8  R1
    {OP_WR, 2'd0, 32'hFFFF_FFFF, 32'h0},         // 9
    {OP_RD, 2'd0, 32'h0, 32'h0000_000D},         // 10 R1
    {OP_EV, 2'd0, 32'h0005_2800, 32'h0},         // 11
    {OP_RD, 2'd1, 32'h0, 32'h0005_2800},         // 12 R2
    {OP_WR, 2'd1, 32'h0001_0800, 32'h0},         // 13
    {OP_RD, 2'd1, 32'h0, 32'h0004_2000},         // 14 R3
    {OP_WR, 2'd1, 32'h0001_0000, 32'h0},         // 15
    {OP_RD, 2'd1, 32'h0, 32'h0004_2000},         // 16 R3
    {OP_WR, 2'd1, 32'h0, 32'h0},                 // 17
    {OP_RD, 2'd1, 32'h0, 32'h0004_2000},         // 18 R3
    {OP_EV, 2'd0, 32'h0000_0021, 32'h0},         // 19
    {OP_RD, 2'd2, 32'h0, 32'h0021_0000},         // 20 R6
    {OP_WR, 2'd2, 32'h0020_0000, 32'h0},         // 21
    {OP_RD, 2'd2, 32'h0, 32'h0001_0000},         // 22 R6
    {OP_OUT,2'd0, 32'h0, 32'h3},                 // 23 R7
    {OP_WR, 2'd3, 32'h0004_0000, 32'h0},         // 24
    {OP_OUT,2'd0, 32'h0, 32'h7},                 // 25 R7
    {OP_WR, 2'd3, 32'hFFFF_FFFF, 32'h0},         // 26
    {OP_RD, 2'd3, 32'h0, 32'hFFFF_3F00},         // 27 R9
    {OP_WR, 2'd1, 32'hFFFF_FFFF, 32'h0},         // 28
    {OP_RD, 2'd1, 32'h0, 32'h0},                 // 29 R3
    {OP_OUT,2'd0, 32'h0, 32'h3},                 // 30 R7
    {OP_RD, 2'd2, 32'h0, 32'h0001_0000}          // 31 R3
  };

  function automatic string vtag(int i);
    if (i <= 2)  return "R8";
    if (i <= 10) return "R1";
    if (i == 12) return "R2";
    if (i <= 22 && i >= 20) return "R6";
    if (i == 27) return "R9";
    if (i == 23 || i == 25 || i == 30) return "R7";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
    tick();
  endtask

  task automatic do_read(input string tag, input logic [1:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(tag, reg_rdata, exp);
  endtask

  task automatic do_pulse(input logic [31:0] d);
    fsync_evt = d[31:16]; gen_av_start = d[13]; gen_vb_start = d[12];
    det_av_start = d[11]; det_vb_start = d[10]; lock_err = d[5:0];
    tick();
    fsync_evt = '0; gen_av_start = 0; gen_vb_start = 0;
    det_av_start = 0; det_vb_start = 0; lock_err = '0;
    tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      case (v[67:66])
        OP_WR:  do_write(v[65:64], v[63:32]);
        OP_RD:  do_read(vtag(i), v[65:64], v[31:0]);
        OP_EV:  do_pulse(v[63:32]);
        default: begin #1; check(vtag(i), {29'b0, irq, gen_en, det_en}, v[31:0]); end
      endcase
    end

    // R4: set and clear of bit 10 in the same cycle
    reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 32'h0000_0400; det_vb_start = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0; det_vb_start = 1'b0;
    tick();
    do_read("R4", 2'd1, 32'h0000_0400);
    do_write(2'd1, 32'hFFFF_FFFF);

    // R5: lock edges latched, level does not re-set
    lock_live = 1'b1; tick(); tick();
    do_read("R5", 2'd1, 32'h0000_0100);
    do_write(2'd1, 32'h0000_0100);
    tick();
    do_read("R5", 2'd1, 32'h0000_0000);
    lock_live = 1'b0; tick(); tick();
    do_read("R5", 2'd1, 32'h0000_0200);
    do_write(2'd1, 32'hFFFF_FFFF);

    // R7: masked event leaves irq low, unmasked raises it
    do_write(2'd3, 32'h0000_0400);
    do_pulse(32'h0000_0800);
    #1; check("R7", {31'b0, irq}, 32'h0);
    do_pulse(32'h0000_0400);
    #1; check("R7", {31'b0, irq}, 32'h1);

    // R2: highest frame-sync and generated vertical blank
    do_write(2'd1, 32'hFFFF_FFFF);
    do_pulse(32'h8000_1000);
    do_read("R2", 2'd1, 32'h8000_1000);

    // R8: reset in mid-run clears everything
    do_pulse(32'h0001_0000 | 32'h3F);
    rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
    do_read("R8", 2'd0, 32'h0);
    do_read("R8", 2'd1, 32'h0);
    do_read("R8", 2'd2, 32'h0);
    do_read("R8", 2'd3, 32'h0);
    #1; check("R8", {29'b0, irq, gen_en, det_en}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule